// File: doc/BRIEF.md
# Multi-Lane SECDED Write Encoder

This block sits on the write-data path of a memory port, between the client stream and the storage that holds protected words. Every incoming data beat is cut into a fixed number of equal lanes. Each lane is turned into its own extended-Hamming codeword that can correct single-bit errors and detect double-bit errors. The codewords are then placed side by side to form a wider output beat. A read-side decoder can then fix or flag each lane on its own.

The encoder is purely combinational. The stream handshake goes straight through, so the block adds no cycle of latency and holds no state. The output byte-enable vector is always driven fully high. A protected word can only be stored whole, because its check bits depend on every data bit. Two parameters set the shape of the block: the lane data width and the number of lanes. The check-bit count and the codeword width are derived from them.

Top module: `swe_write_encoder`

## Requirements
- R1: A lane of LANE_W data bits becomes a codeword of LANE_W + C + 1 bits, where C is the smallest count with 2^C >= LANE_W + C + 1. This gives 8 -> 13, 32 -> 39 (C = 6) and 64 -> 72 (C = 7).
- R2: Codeword bit 0 holds the overall parity. It equals the XOR of codeword bits 1 and up, so every codeword has an even number of ones.
- R3: Codeword positions 1, 2, 4, 8, ... hold the check bits. The check bit at position 2^k is the XOR of all data bits whose codeword position has bit k set. As a result, the XOR of the positions of all set bits in positions 1 and up is zero.
- R4: Data bit j of a lane sits at the (j+1)-th codeword position, counting upward from 1, that is not a power of two. For example, data bits 0, 1, 2, 3 and 4 land at positions 3, 5, 6, 7 and 9, and bit 31 of a 32-bit lane lands at position 38.
- R5: Lane i takes input bits [i*LANE_W +: LANE_W]. Its codeword occupies output bits [i*CW_W +: CW_W], so lane 0 is at the least significant end.
- R6: Every bit of source_be is 1, whatever the value of sink_be.
- R7: source_valid equals sink_valid and sink_ready equals source_ready, with no clock cycle in between. source_data follows sink_data in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sink_valid | input | 1 | Input beat valid |
| sink_ready | output | 1 | Input beat accepted (copy of source_ready) |
| sink_data | input | LANES*LANE_W | Raw data beat, lane 0 in the low bits |
| sink_be | input | LANES*LANE_W/8 | Input byte enables (not used for the output) |
| source_valid | output | 1 | Encoded beat valid (copy of sink_valid) |
| source_ready | input | 1 | Downstream ready |
| source_data | output | LANES*CW_W | Concatenated codewords, lane 0 in the low bits |
| source_be | output | ceil(LANES*CW_W/8) | Output byte enables, always all ones |

## Verification
The bound checker looks at every change of the ports. It checks that each output codeword has even parity and a zero Hamming syndrome. It checks that the data bits read back from the non-power-of-two positions equal the matching input lane. It also checks that the handshake is passed straight through and that the byte enables are all ones. These checks can only relate the output to the input, so they cannot tell a wrong but self-consistent placement convention from the intended one. The bench's hand-worked codewords pin the exact positions of the check bits and the parity bit. Its rotated lane table pins which output slot each lane lands in. Its 8-bit and 64-bit instances show that the widths derived from the parameters hold.

// File: rtl/swe_pkg.sv
// Package: swe_pkg
// Shared width arithmetic and position masks for the SECDED write encoder.
// Assumes codewords no wider than MAX_CW bits.
package swe_pkg;

    localparam int MAX_CW = 256;

    // Number of Hamming check bits needed to cover a lane of the given width.
    function automatic int chk_count(input int lane_w);
        int r;
        r = 0;
        while ((1 << r) < lane_w + r + 1) r++;
        return r;
    endfunction

    // Full codeword width: data, check bits and one overall parity bit.
    function automatic int cw_width(input int lane_w);
        return lane_w + chk_count(lane_w) + 1;
    endfunction

    // True when a codeword position is a power of two (a check-bit slot).
    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Mask of the data positions that check bit k covers.
    function automatic logic [MAX_CW-1:0] cover_mask(input int cw_w, input int k);
        logic [MAX_CW-1:0] m;
        m = '0;
        for (int p = 1; p < cw_w; p++) begin
            if ((((p >> k) & 1) == 1) && !is_pow2(p)) m[p] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/swe_scatter.sv
// Module: swe_scatter
// Moves the data bits of one lane to their Hamming positions. The data bits
// go, in ascending order, to the codeword positions that are not powers of
// two. Position 0 and the power-of-two positions are left at zero.
// Assumes LANE_W >= 1. Purely combinational.
module swe_scatter #(
    parameter int LANE_W = 32,
    localparam int CW_W  = swe_pkg::cw_width(LANE_W)
) (
    input  logic [LANE_W-1:0] data,
    output logic [CW_W-1:0]   slots
);

    // Per position: a data bit, or zero for parity and check slots.
    for (genvar p = 0; p < CW_W; p++) begin : g_pos
        if (p == 0 || swe_pkg::is_pow2(p)) begin : g_hole
            assign slots[p] = 1'b0;
        end else begin : g_data
            // Position p is preceded by clog2(p+1) power-of-two slots.
            assign slots[p] = data[p - $clog2(p + 1) - 1];
        end
    end

endmodule

// File: rtl/swe_check_gen.sv
// Module: swe_check_gen
// Works out the Hamming check bits of one lane from its scattered data.
// Assumes the input has zero at position 0 and at every power-of-two position.
module swe_check_gen #(
    parameter int LANE_W = 32,
    localparam int CHK_W = swe_pkg::chk_count(LANE_W),
    localparam int CW_W  = swe_pkg::cw_width(LANE_W)
) (
    input  logic [CW_W-1:0]  slots,
    output logic [CHK_W-1:0] chk
);

    // One XOR tree per check bit, over the positions that have bit k set.
    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam logic [CW_W-1:0] COVER = CW_W'(swe_pkg::cover_mask(CW_W, k));
        assign chk[k] = ^(slots & COVER);
    end

endmodule

// File: rtl/swe_lane_enc.sv
// Module: swe_lane_enc
// Encodes one data lane into an extended-Hamming codeword. Bit 0 holds the
// overall parity and the check bits sit at positions 1, 2, 4, ...
// Purely combinational.
module swe_lane_enc #(
    parameter int LANE_W = 32,
    localparam int CHK_W = swe_pkg::chk_count(LANE_W),
    localparam int CW_W  = swe_pkg::cw_width(LANE_W)
) (
    input  logic [LANE_W-1:0] data,
    output logic [CW_W-1:0]   cw
);

    logic [CW_W-1:0]  slots;
    logic [CW_W-1:0]  body;
    logic [CHK_W-1:0] chk;
    logic             parity;

    swe_scatter #(.LANE_W(LANE_W)) u_scatter (
        .data  (data),
        .slots (slots)
    );

    swe_check_gen #(.LANE_W(LANE_W)) u_check (
        .slots (slots),
        .chk   (chk)
    );

    // Merge check bits into their slots. The scatter stage left those slots clear.
    for (genvar p = 0; p < CW_W; p++) begin : g_merge
        if (swe_pkg::is_pow2(p)) begin : g_chk
            assign body[p] = slots[p] | chk[$clog2(p)];
        end else begin : g_pass
            assign body[p] = slots[p];
        end
    end

    // Overall parity over the whole codeword body (position 0 is still zero).
    assign parity = ^body;
    assign cw     = {body[CW_W-1:1], parity};

endmodule

// File: rtl/swe_write_encoder.sv
// Module: swe_write_encoder
// Top level of the multi-lane SECDED write encoder. Splits a beat into
// LANES lanes, encodes each one and concatenates the codewords, with lane 0
// at the low end. Valid and ready pass straight through. The output byte
// enables are forced high, because a codeword can only be written whole.
// Assumes LANE_W is a multiple of 8. Purely combinational.
module swe_write_encoder #(
    parameter int LANE_W = 32,
    parameter int LANES  = 8,
    localparam int CW_W     = swe_pkg::cw_width(LANE_W),
    localparam int IN_W     = LANES * LANE_W,
    localparam int OUT_W    = LANES * CW_W,
    localparam int BE_IN_W  = IN_W / 8,
    localparam int BE_OUT_W = (OUT_W + 7) / 8
) (
    input  logic                sink_valid,
    output logic                sink_ready,
    input  logic [IN_W-1:0]     sink_data,
    input  logic [BE_IN_W-1:0]  sink_be,
    output logic                source_valid,
    input  logic                source_ready,
    output logic [OUT_W-1:0]    source_data,
    output logic [BE_OUT_W-1:0] source_be
);

    // One encoder per lane, each in its own output slot.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        swe_lane_enc #(.LANE_W(LANE_W)) u_enc (
            .data (sink_data[i*LANE_W +: LANE_W]),
            .cw   (source_data[i*CW_W +: CW_W])
        );
    end

    // Handshake passes straight through.
    assign source_valid = sink_valid;
    assign sink_ready   = source_ready;

    // Whole-codeword writes only: every output byte enabled.
    assign source_be = '1;

endmodule

// File: rtl/swe_write_encoder_chk.sv
// Module: swe_write_encoder_chk
// Port-level checker for swe_write_encoder, attached with bind. It reads
// each codeword back with its own syndrome and extraction logic and
// compares the result with the input lane. Immediate assertions are skipped
// while the inputs are unknown.
module swe_write_encoder_chk #(
    parameter int LANE_W = 32,
    parameter int LANES  = 8,
    localparam int CHK_W    = swe_pkg::chk_count(LANE_W),
    localparam int CW_W     = swe_pkg::cw_width(LANE_W),
    localparam int IN_W     = LANES * LANE_W,
    localparam int OUT_W    = LANES * CW_W,
    localparam int BE_IN_W  = IN_W / 8,
    localparam int BE_OUT_W = (OUT_W + 7) / 8
) (
    input logic                sink_valid,
    input logic                sink_ready,
    input logic [IN_W-1:0]     sink_data,
    input logic [BE_IN_W-1:0]  sink_be,
    input logic                source_valid,
    input logic                source_ready,
    input logic [OUT_W-1:0]    source_data,
    input logic [BE_OUT_W-1:0] source_be
);

    // Handshake and byte-enable relations.
    always_comb begin
        if (!$isunknown(sink_valid)) begin
            assert_valid_pass_R7: assert (source_valid == sink_valid)
                else $error("R7 source_valid does not follow sink_valid");
        end
        if (!$isunknown(source_ready)) begin
            assert_ready_pass_R7: assert (sink_ready == source_ready)
                else $error("R7 sink_ready does not follow source_ready");
        end
        if (!$isunknown(sink_be)) begin
            assert_be_all_ones_R6: assert (source_be == {BE_OUT_W{1'b1}})
                else $error("R6 source_be %0h with sink_be %0h", source_be, sink_be);
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [CW_W-1:0]   cw;
        logic [LANE_W-1:0] d_in;
        logic [LANE_W-1:0] d_out;
        logic [CHK_W-1:0]  syn;

        assign cw   = source_data[i*CW_W +: CW_W];
        assign d_in = sink_data[i*LANE_W +: LANE_W];

        // Syndrome and data extraction from the codeword of this lane.
        always_comb begin
            int n;
            syn   = '0;
            d_out = '0;
            n     = 0;
            for (int p = 1; p < CW_W; p++) begin
                if (cw[p]) syn = syn ^ CHK_W'(p);
                if ((p & (p - 1)) != 0) begin
                    d_out[n] = cw[p];
                    n++;
                end
            end
        end

        // Per-lane code properties.
        always_comb begin
            if (!$isunknown(cw)) begin
                assert_even_parity_R2: assert ((^cw) == 1'b0)
                    else $error("R2 lane %0d odd parity %0h", i, cw);
                assert_zero_syndrome_R3: assert (syn == '0)
                    else $error("R3 lane %0d syndrome %0h", i, syn);
            end
            if (!$isunknown({cw, d_in})) begin
                assert_data_slots_R4_R5: assert (d_out == d_in)
                    else $error("R4 R5 lane %0d data %0h expected %0h", i, d_out, d_in);
            end
        end
    end

endmodule

bind swe_write_encoder swe_write_encoder_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
) u_chk (
    .sink_valid   (sink_valid),
    .sink_ready   (sink_ready),
    .sink_data    (sink_data),
    .sink_be      (sink_be),
    .source_valid (source_valid),
    .source_ready (source_ready),
    .source_data  (source_data),
    .source_be    (source_be)
);

// File: tb/swe_write_encoder_tb.sv
// Testbench for swe_write_encoder: a table of hand-worked lane codewords
// walked with rotation across lanes, then directed tests.
module swe_write_encoder_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic         s_valid, m_ready;
    logic         s_ready, m_valid, s_ready8, m_valid8, s_ready64, m_valid64;
    logic [255:0] s_data;
    logic [31:0]  s_be;
    logic [311:0] m_data;
    logic [38:0]  m_be;
    logic [63:0]  s_data8;
    logic [7:0]   s_be8;
    logic [103:0] m_data8;
    logic [12:0]  m_be8;
    logic [511:0] s_data64;
    logic [63:0]  s_be64;
    logic [575:0] m_data64;
    logic [71:0]  m_be64;

    swe_write_encoder #(.LANE_W(32), .LANES(8)) u_dut (
        .sink_valid (s_valid), .sink_ready (s_ready), .sink_data (s_data), .sink_be (s_be),
        .source_valid (m_valid), .source_ready (m_ready), .source_data (m_data), .source_be (m_be)
    );
    swe_write_encoder #(.LANE_W(8), .LANES(8)) u_dut8 (
        .sink_valid (s_valid), .sink_ready (s_ready8), .sink_data (s_data8), .sink_be (s_be8),
        .source_valid (m_valid8), .source_ready (m_ready), .source_data (m_data8), .source_be (m_be8)
    );
    swe_write_encoder #(.LANE_W(64), .LANES(8)) u_dut64 (
        .sink_valid (s_valid), .sink_ready (s_ready64), .sink_data (s_data64), .sink_be (s_be64),
        .source_valid (m_valid64), .source_ready (m_ready), .source_data (m_data64), .source_be (m_be64)
    );

    // Hand-worked 32-bit lane codewords (R3, R4 positions, R2 parity at bit 0).
    typedef struct packed {
        logic [31:0] d;
        logic [38:0] cw;
    } vec_t;
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 39'h00_0000_0000},
        '{32'h0000_0001, 39'h00_0000_000F},
        '{32'h0000_0002, 39'h00_0000_0033},
        '{32'h0000_0003, 39'h00_0000_003C},
        '{32'h0000_0004, 39'h00_0000_0055},
        '{32'h0000_0008, 39'h00_0000_0096},
        '{32'h0000_000F, 39'h00_0000_00FF},
        '{32'h0000_0010, 39'h00_0000_0303},
        '{32'h8000_0000, 39'h41_0000_0014},
        '{32'h8000_0001, 39'h41_0000_001B}
    };

    // Reference lane encoder written from the requirements.
    function automatic logic [127:0] ref_lane(input logic [63:0] d, input int w);
        logic [127:0] cw;
        int r, pos, syn;
        case (w)
            8:       r = 4;
            32:      r = 6;
            default: r = 7;
        endcase
        cw  = '0;
        syn = 0;
        pos = 1;
        for (int j = 0; j < w; j++) begin
            while ((pos & (pos - 1)) == 0) pos++;
            if (d[j]) begin
                cw[pos] = 1'b1;
                syn = syn ^ pos;
            end
            pos++;
        end
        for (int k = 0; k < r; k++) cw[1 << k] = syn[k];
        cw[0] = ^cw;
        return cw;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [639:0] act, input logic [639:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all three instances against the reference for the current inputs.
    task automatic check_ref(input string tag);
        logic [311:0] e32;
        logic [103:0] e8;
        logic [575:0] e64;
        logic [127:0] t;
        bit par_ok;
        for (int i = 0; i < 8; i++) begin
            t = ref_lane({32'h0, s_data[i*32 +: 32]}, 32);
            e32[i*39 +: 39] = t[38:0];
            t = ref_lane({56'h0, s_data8[i*8 +: 8]}, 8);
            e8[i*13 +: 13] = t[12:0];
            t = ref_lane(s_data64[i*64 +: 64], 64);
            e64[i*72 +: 72] = t[71:0];
        end
        check(m_data == e32, {tag, " R3 R4 R5 32-bit lanes"}, 640'(m_data), 640'(e32));
        check(m_data8 == e8, {tag, " R1 8-bit lanes to 13"}, 640'(m_data8), 640'(e8));
        check(m_data64 == e64, {tag, " R1 64-bit lanes to 72"}, 640'(m_data64), 640'(e64));
        par_ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (m_data[i*39] != ^m_data[i*39+1 +: 38]) par_ok = 1'b0;
        end
        check(par_ok, {tag, " R2 bit 0 is parity of the rest"}, 640'(m_data), 640'(e32));
    endtask

    // Main stimulus.
    initial begin
        s_valid = 1'b0; m_ready = 1'b0;
        s_data = '0; s_be = '0; s_data8 = '0; s_be8 = '0; s_data64 = '0; s_be64 = '0;
        @(negedge clk); #2;

        // Idle state: nothing valid, zero data encodes to zero, enables high.
        check(m_valid == 1'b0 && s_ready == 1'b0, "R7 idle handshake",
              640'({m_valid, s_ready}), 640'(0));
        check(m_data == '0, "R2 R3 idle zero codewords", 640'(m_data), 640'(0));
        check(m_be == '1, "R6 idle enables", 640'(m_be), 640'({39{1'b1}}));

        // Table walk: row r puts VECS[(r+i)%NV] into lane i.
        for (int r = 0; r < NV; r++) begin
            logic [311:0] exp;
            @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                s_data[i*32 +: 32] = VECS[(r + i) % NV].d;
                exp[i*39 +: 39]    = VECS[(r + i) % NV].cw;
            end
            #2;
            check(m_data == exp, $sformatf("R2 R3 R4 R5 table row %0d", r),
                  640'(m_data), 640'(exp));
        end

        // Corner data: all ones in every lane.
        @(negedge clk);
        s_data = '1; s_data8 = '1; s_data64 = '1;
        #2;
        check_ref("all-ones");

        // Random beats against the reference.
        for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            for (int c = 0; c < 16; c++) s_data64[c*32 +: 32] = $urandom;
            s_data  = s_data64[255:0];
            s_data8 = s_data64[319:256];
            #2;
            check_ref($sformatf("random beat %0d", n));
        end

        // Handshake passthrough for all four combinations.
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            s_valid = c[0];
            m_ready = c[1];
            #2;
            check(m_valid == c[0] && s_ready == c[1] && m_valid8 == c[0] && s_ready64 == c[1],
                  $sformatf("R7 handshake combo %0d", c),
                  640'({m_valid, s_ready}), 640'({c[0], c[1]}));
        end

        // Byte enables ignore the input enables.
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            case (c)
                0:       begin s_be = '0; s_be8 = '0; s_be64 = '0; end
                1:       begin s_be = $urandom; s_be8 = 8'h5A; s_be64 = {$urandom, $urandom}; end
                default: begin s_be = '1; s_be8 = '1; s_be64 = '1; end
            endcase
            #2;
            check(m_be == '1 && m_be8 == '1 && m_be64 == '1,
                  $sformatf("R6 enables with input pattern %0d", c),
                  640'({m_be8, m_be}), 640'({13'h1FFF, {39{1'b1}}}));
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule